// File: doc/BRIEF.md
# Accumulator ALU with flag logic

This block is the arithmetic and logic unit of a small 8-bit accumulator machine. It is purely combinational. One operand comes from the accumulator (`opA`) and the other comes from an operand-select mux (`opB`). A 4-bit mode code picks one of sixteen operations: addition and subtraction in either direction, two pass-through modes, three bitwise operations, increment, decrement, two rotates, three shifts and two's-complement negation. The block returns the result and the next value of the four status flags.

Every mode rewrites only its own subset of the flags. Each remaining flag is copied unchanged from `flagsIn`, so the enclosing machine can load all four flags every time without any masking of its own. For shifts, the carry flag takes the last bit that left the operand. A shift count of zero leaves Z and C exactly as they arrived. When `enable` is low, the block returns zero and hands the flags through untouched.

Inside the block, a decoder turns the mode into a small bundle of strobes. A separate datapath computes all candidate results and applies the flag-update strobes.

Top module: `accum_alu`

## Requirements
- R1: Mode 0 gives opA+opB, mode 1 gives opA−opB and mode 7 gives opB−opA, each modulo 256. All four flags are updated. C is the carry-out (for subtraction, C=1 means no borrow) and O is signed overflow.
- R2: Mode 8 gives opB+1, mode 9 gives opB−1 and mode 15 gives 0−opB. All four flags are updated with the same carry convention as R1, so 0−0 sets C=1 and 0−0x80 sets O=1.
- R3: Mode 2 passes opA and mode 3 passes opB. No flag changes.
- R4: Modes 4, 5 and 6 give AND, OR and XOR of opA and opB. Only Z is updated; C, S and O are copied from flagsIn.
- R5: Mode 10 rotates opB left and mode 11 rotates it right, each by opA[2:0]. No flag changes; for example, 0x80 rotated left by 1 gives 0x01.
- R6: Mode 12 (logical left) and mode 13 (logical right) shift opB by opA[2:0] and fill with zeros. C becomes the last bit shifted out and Z is updated; S and O are kept. For example, 0x80<<1 gives 0x00 with C=1, and 0x04>>3 gives 0x00 with C=1.
- R7: Mode 14 shifts opB right arithmetically by opA[2:0], replicating the original MSB. Z, C and S are updated and O is kept. For example, 0x81 by 1 gives 0xC0 with C=1.
- R8: For modes 12 to 14 with opA[2:0]=0, the result equals opB and Z and C keep their flagsIn values. In mode 14, S is still taken from the result.
- R9: flagsIn and flagsOut are ordered Z,C,S,O from bit 3 down to bit 0. When Z is updated it is 1 exactly when the result is zero. When S is updated it equals result bit 7.
- R10: While enable is low, the result is 0x00 and flagsOut equals flagsIn in every mode.
- R11: Shift and rotate counts use only opA[2:0]; opA[7:3] has no effect on those modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| enable | input | 1 | Operation enable; low forces a zero result and flag pass-through |
| mode | input | 4 | Operation select code |
| opA | input | 8 | Operand 1 (accumulator side); its low 3 bits are the shift/rotate count |
| opB | input | 8 | Operand 2 (memory or immediate side) |
| flagsIn | input | 4 | Current flags {Z,C,S,O} |
| result | output | 8 | Operation result |
| flagsOut | output | 4 | Next flags {Z,C,S,O} |

## Verification
The delicate overlap is a shift whose count is zero. In that case two behaviours act on the same flag vector in one evaluation: the zero-count hold of Z and C, and the normal flag update, which for the arithmetic right shift still writes S. The bench provokes this by applying modes 12, 13 and 14 with opA[2:0]=0. It sets opA[7:3] nonzero and drives flagsIn with values opposite to what a fresh update would produce. A vector passes only when Z and C match flagsIn while S (mode 14) matches the MSB of the unshifted operand. Randomized vectors over all modes then compare every result and flag with an independent bit-loop model.

// File: rtl/accalu_pkg.sv
package accalu_pkg;

  localparam int FLAG_Z = 3;
  localparam int FLAG_C = 2;
  localparam int FLAG_S = 1;
  localparam int FLAG_O = 0;
  localparam int NUM_FLAGS = 4;

  typedef enum logic [1:0] {
    GRP_ARITH = 2'd0,
    GRP_LOGIC = 2'd1,
    GRP_SHIFT = 2'd2,
    GRP_PASS  = 2'd3
  } grp_e;

  typedef enum logic [1:0] {
    XSEL_A    = 2'd0,
    XSEL_B    = 2'd1,
    XSEL_ZERO = 2'd2
  } xsel_e;

  typedef enum logic [1:0] {
    YSEL_B   = 2'd0,
    YSEL_A   = 2'd1,
    YSEL_ONE = 2'd2
  } ysel_e;

  typedef enum logic [1:0] {
    LOP_AND = 2'd0,
    LOP_OR  = 2'd1,
    LOP_XOR = 2'd2
  } lop_e;

  typedef struct packed {
    logic  active;
    grp_e  grp;
    xsel_e addX;
    ysel_e addY;
    logic  invY;
    lop_e  logicOp;
    logic  passB;
    logic  shRot;
    logic  shRight;
    logic  shArith;
    logic  updZ;
    logic  updC;
    logic  updS;
    logic  updO;
  } strobe_t;

endpackage

// File: rtl/accalu_ctrl.sv
module accalu_ctrl
  import accalu_pkg::*;
(
  input  logic       enable,
  input  logic [3:0] mode,
  input  logic       cntZero,
  output strobe_t    st
);

  always_comb begin
    st = '0;
    st.active = enable;
    unique case (mode)
      4'h0: begin st.grp = GRP_ARITH; st.addX = XSEL_A; st.addY = YSEL_B; end
      4'h1: begin st.grp = GRP_ARITH; st.addX = XSEL_A; st.addY = YSEL_B; st.invY = 1'b1; end
      4'h2: begin st.grp = GRP_PASS; st.passB = 1'b0; end
      4'h3: begin st.grp = GRP_PASS; st.passB = 1'b1; end
      4'h4: begin st.grp = GRP_LOGIC; st.logicOp = LOP_AND; end
      4'h5: begin st.grp = GRP_LOGIC; st.logicOp = LOP_OR; end
      4'h6: begin st.grp = GRP_LOGIC; st.logicOp = LOP_XOR; end
      4'h7: begin st.grp = GRP_ARITH; st.addX = XSEL_B; st.addY = YSEL_A; st.invY = 1'b1; end
      4'h8: begin st.grp = GRP_ARITH; st.addX = XSEL_B; st.addY = YSEL_ONE; end
      4'h9: begin st.grp = GRP_ARITH; st.addX = XSEL_B; st.addY = YSEL_ONE; st.invY = 1'b1; end
      4'hA: begin st.grp = GRP_SHIFT; st.shRot = 1'b1; end
      4'hB: begin st.grp = GRP_SHIFT; st.shRot = 1'b1; st.shRight = 1'b1; end
      4'hC: begin st.grp = GRP_SHIFT; end
      4'hD: begin st.grp = GRP_SHIFT; st.shRight = 1'b1; end
      4'hE: begin st.grp = GRP_SHIFT; st.shRight = 1'b1; st.shArith = 1'b1; end
      4'hF: begin st.grp = GRP_ARITH; st.addX = XSEL_ZERO; st.addY = YSEL_B; st.invY = 1'b1; end
      default: st.grp = GRP_PASS;
    endcase

    // Flag-update subsets per group
    unique case (st.grp)
      GRP_ARITH: begin st.updZ = 1'b1; st.updC = 1'b1; st.updS = 1'b1; st.updO = 1'b1; end
      GRP_LOGIC: st.updZ = 1'b1;
      GRP_SHIFT: if (!st.shRot) begin
                   st.updZ = !cntZero;
                   st.updC = !cntZero;
                   st.updS = st.shArith;
                 end
      default: ;
    endcase

    if (!enable) begin
      st.updZ = 1'b0;
      st.updC = 1'b0;
      st.updS = 1'b0;
      st.updO = 1'b0;
    end
  end

  // Checks on the decoded strobes
  always_comb begin
    if (enable && mode inside {4'h4, 4'h5, 4'h6})
      a_r4_logic_only_z: assert (st.updZ && !st.updC && !st.updS && !st.updO)
        else $error("R4: logic mode updates a flag other than Z");
    if (mode inside {4'hC, 4'hD, 4'hE} && cntZero)
      a_r8_zero_count_hold: assert (!st.updZ && !st.updC)
        else $error("R8: zero-count shift requests a Z/C update");
    if (mode inside {4'h2, 4'h3, 4'hA, 4'hB})
      a_r5_no_flag_modes: assert (!st.updZ && !st.updC && !st.updS && !st.updO)
        else $error("R5: pass/rotate mode requests a flag update");
  end

endmodule

// File: rtl/accalu_dp.sv
module accalu_dp
  import accalu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  strobe_t              st,
  input  logic [WIDTH-1:0]     opA,
  input  logic [WIDTH-1:0]     opB,
  input  logic [NUM_FLAGS-1:0] flagsIn,
  output logic [WIDTH-1:0]     result,
  output logic [NUM_FLAGS-1:0] flagsOut
);

  localparam int CNT_W = $clog2(WIDTH);
  localparam int MSB   = WIDTH - 1;

  logic [CNT_W-1:0] cnt;
  logic [WIDTH-1:0] addXv, addYv, yEff, sum;
  logic             addCarry, addOvf;
  logic [WIDTH-1:0] logicRes;
  logic [WIDTH:0]   lsExt, rsExt, asExt;
  logic [2*WIDTH-1:0] rotlExt, rotrExt;
  logic [WIDTH-1:0] shRes;
  logic             shCarry;
  logic [WIDTH-1:0] rawRes;
  logic             rawC;

  assign cnt = opA[CNT_W-1:0];

  // Shared adder: x + (y or ~y) + invY
  always_comb begin
    unique case (st.addX)
      XSEL_B:    addXv = opB;
      XSEL_ZERO: addXv = '0;
      default:   addXv = opA;
    endcase
    unique case (st.addY)
      YSEL_A:   addYv = opA;
      YSEL_ONE: addYv = {{(WIDTH-1){1'b0}}, 1'b1};
      default:  addYv = opB;
    endcase
    yEff = st.invY ? ~addYv : addYv;
    {addCarry, sum} = {1'b0, addXv} + {1'b0, yEff} + {{WIDTH{1'b0}}, st.invY};
    addOvf = (addXv[MSB] == yEff[MSB]) && (sum[MSB] != addXv[MSB]);
  end

  always_comb begin
    unique case (st.logicOp)
      LOP_OR:  logicRes = opA | opB;
      LOP_XOR: logicRes = opA ^ opB;
      default: logicRes = opA & opB;
    endcase
  end

  // Shifter and rotator; the extra bit catches the last bit shifted out
  always_comb begin
    lsExt   = {1'b0, opB} << cnt;
    rsExt   = {opB, 1'b0} >> cnt;
    asExt   = $signed({opB, 1'b0}) >>> cnt;
    rotlExt = {opB, opB} << cnt;
    rotrExt = {opB, opB} >> cnt;
    if (st.shRot) begin
      shRes   = st.shRight ? rotrExt[WIDTH-1:0] : rotlExt[2*WIDTH-1:WIDTH];
      shCarry = 1'b0;
    end else if (!st.shRight) begin
      shRes   = lsExt[WIDTH-1:0];
      shCarry = lsExt[WIDTH];
    end else if (st.shArith) begin
      shRes   = asExt[WIDTH:1];
      shCarry = asExt[0];
    end else begin
      shRes   = rsExt[WIDTH:1];
      shCarry = rsExt[0];
    end
  end

  always_comb begin
    unique case (st.grp)
      GRP_ARITH: begin rawRes = sum;      rawC = addCarry; end
      GRP_LOGIC: begin rawRes = logicRes; rawC = 1'b0;     end
      GRP_SHIFT: begin rawRes = shRes;    rawC = shCarry;  end
      default:   begin rawRes = st.passB ? opB : opA; rawC = 1'b0; end
    endcase
    result = st.active ? rawRes : '0;
    flagsOut[FLAG_Z] = st.updZ ? (rawRes == '0) : flagsIn[FLAG_Z];
    flagsOut[FLAG_C] = st.updC ? rawC           : flagsIn[FLAG_C];
    flagsOut[FLAG_S] = st.updS ? rawRes[MSB]    : flagsIn[FLAG_S];
    flagsOut[FLAG_O] = st.updO ? addOvf         : flagsIn[FLAG_O];
  end

  // Checks between decoded strobes and produced outputs
  always_comb begin
    if (!st.active)
      a_r10_idle_passthrough: assert (result == '0 && flagsOut == flagsIn)
        else $error("R10: disabled ALU altered result or flags");
    if (st.updZ)
      a_r9_zero_tracks_result: assert (flagsOut[FLAG_Z] == (result == '0))
        else $error("R9: Z disagrees with result");
    if (st.updS)
      a_r9_sign_tracks_result: assert (flagsOut[FLAG_S] == result[MSB])
        else $error("R9: S disagrees with result MSB");
    if (!st.updO)
      a_r4_o_kept: assert (flagsOut[FLAG_O] == flagsIn[FLAG_O])
        else $error("R4: O changed without update strobe");
  end

endmodule

// File: rtl/accum_alu.sv
module accum_alu
  import accalu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             enable,
  input  logic [3:0]       mode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [3:0]       flagsIn,
  output logic [WIDTH-1:0] result,
  output logic [3:0]       flagsOut
);

  localparam int CNT_W = $clog2(WIDTH);

  strobe_t st;
  logic    cntZero;

  assign cntZero = (opA[CNT_W-1:0] == '0);

  accalu_ctrl u_ctrl (
    .enable  (enable),
    .mode    (mode),
    .cntZero (cntZero),
    .st      (st)
  );

  accalu_dp #(.WIDTH(WIDTH)) u_dp (
    .st       (st),
    .opA      (opA),
    .opB      (opB),
    .flagsIn  (flagsIn),
    .result   (result),
    .flagsOut (flagsOut)
  );

endmodule

// File: tb/tb_accum_alu.sv
`timescale 1ns/1ps
module tb_accum_alu;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic       enable = 1'b0;
  logic [3:0] mode = '0;
  logic [7:0] opA = '0, opB = '0;
  logic [3:0] flagsIn = '0;
  logic [7:0] result;
  logic [3:0] flagsOut;

  accum_alu dut (
    .enable(enable), .mode(mode), .opA(opA), .opB(opB),
    .flagsIn(flagsIn), .result(result), .flagsOut(flagsOut)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [7:0] expRes[$];
  logic [3:0] expFlg[$];
  string      expTag[$];

  // Independent reference model written from the requirements
  function automatic void model(input logic en, input logic [3:0] m,
                                input logic [7:0] a, input logic [7:0] b,
                                input logic [3:0] fin,
                                output logic [7:0] r, output logic [3:0] f);
    int ur, sres, n;
    logic c, o, upz, upc, ups, upo, last;
    logic [7:0] t;
    n = int'(a[2:0]);
    ur = 0; sres = 0; c = 0; o = 0; last = 0; t = b;
    upz = 0; upc = 0; ups = 0; upo = 0;
    case (m)
      4'h0: begin ur = int'(a) + int'(b); c = ur > 255; sres = int'($signed(a)) + int'($signed(b)); end
      4'h1: begin ur = int'(a) - int'(b); c = a >= b; sres = int'($signed(a)) - int'($signed(b)); end
      4'h7: begin ur = int'(b) - int'(a); c = b >= a; sres = int'($signed(b)) - int'($signed(a)); end
      4'h8: begin ur = int'(b) + 1; c = ur > 255; sres = int'($signed(b)) + 1; end
      4'h9: begin ur = int'(b) - 1; c = b >= 8'd1; sres = int'($signed(b)) - 1; end
      4'hF: begin ur = 0 - int'(b); c = (b == 8'd0); sres = 0 - int'($signed(b)); end
      default: ;
    endcase
    if (m inside {4'h0, 4'h1, 4'h7, 4'h8, 4'h9, 4'hF}) begin
      r = ur[7:0]; o = (sres > 127) || (sres < -128);
      upz = 1; upc = 1; ups = 1; upo = 1;
    end else begin
      case (m)
        4'h2: r = a;
        4'h3: r = b;
        4'h4: begin r = a & b; upz = 1; end
        4'h5: begin r = a | b; upz = 1; end
        4'h6: begin r = a ^ b; upz = 1; end
        4'hA: begin for (int k = 0; k < n; k++) t = {t[6:0], t[7]}; r = t; end
        4'hB: begin for (int k = 0; k < n; k++) t = {t[0], t[7:1]}; r = t; end
        4'hC: begin for (int k = 0; k < n; k++) begin last = t[7]; t = {t[6:0], 1'b0}; end
                    r = t; c = last; upz = (n != 0); upc = (n != 0); end
        4'hD: begin for (int k = 0; k < n; k++) begin last = t[0]; t = {1'b0, t[7:1]}; end
                    r = t; c = last; upz = (n != 0); upc = (n != 0); end
        default: begin for (int k = 0; k < n; k++) begin last = t[0]; t = {t[7], t[7:1]}; end
                    r = t; c = last; upz = (n != 0); upc = (n != 0); ups = 1; end
      endcase
    end
    f[3] = upz ? (r == 8'd0) : fin[3];
    f[2] = upc ? c : fin[2];
    f[1] = ups ? r[7] : fin[1];
    f[0] = upo ? o : fin[0];
    if (!en) begin r = 8'd0; f = fin; end
  endfunction

  function automatic string tagOf(input logic en, input logic [3:0] m);
    if (!en) return "R10";
    case (m)
      4'h0, 4'h1, 4'h7: return "R1";
      4'h8, 4'h9, 4'hF: return "R2";
      4'h2, 4'h3: return "R3";
      4'h4, 4'h5, 4'h6: return "R4";
      4'hA, 4'hB: return "R5";
      4'hC, 4'hD: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Driver: apply one vector per cycle, push expectation
  task automatic apply(input logic en, input logic [3:0] m, input logic [7:0] a,
                       input logic [7:0] b, input logic [3:0] fin, input string tag);
    logic [7:0] r;
    logic [3:0] f;
    @(posedge clk);
    enable = en; mode = m; opA = a; opB = b; flagsIn = fin;
    model(en, m, a, b, fin, r, f);
    expRes.push_back(r);
    expFlg.push_back(f);
    expTag.push_back(tag);
  endtask

  // Monitor: compare on the falling edge
  always @(negedge clk) begin
    if (expRes.size() > 0) begin
      logic [7:0] er;
      logic [3:0] ef;
      string tg;
      er = expRes.pop_front();
      ef = expFlg.pop_front();
      tg = expTag.pop_front();
      vectors++;
      if (result !== er || flagsOut !== ef) begin
        miscompares++;
        $display("FAIL %s mode=%h opA=%h opB=%h fin=%b: result=%h flags=%b expected result=%h flags=%b",
                 tg, mode, opA, opB, flagsIn, result, flagsOut, er, ef);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R10: idle state with enable low, several modes
    apply(1'b0, 4'h0, 8'h12, 8'h34, 4'b1010, "R10");
    apply(1'b0, 4'hC, 8'h01, 8'h80, 4'b0101, "R10");
    // R1: add/sub both directions, carry and overflow corners
    apply(1'b1, 4'h0, 8'h7F, 8'h01, 4'b0000, "R1");
    apply(1'b1, 4'h0, 8'hFF, 8'h01, 4'b0000, "R1");
    apply(1'b1, 4'h1, 8'h05, 8'h05, 4'b0000, "R1");
    apply(1'b1, 4'h1, 8'h80, 8'h01, 4'b1111, "R1");
    apply(1'b1, 4'h7, 8'h03, 8'h01, 4'b0000, "R1");
    // R2: inc/dec/neg corners
    apply(1'b1, 4'h8, 8'h00, 8'h7F, 4'b0000, "R2");
    apply(1'b1, 4'h9, 8'h00, 8'h00, 4'b0000, "R2");
    apply(1'b1, 4'hF, 8'h00, 8'h80, 4'b0000, "R2");
    apply(1'b1, 4'hF, 8'h00, 8'h00, 4'b0000, "R2");
    // R3: pass modes keep flags
    apply(1'b1, 4'h2, 8'h00, 8'h55, 4'b0110, "R3");
    apply(1'b1, 4'h3, 8'hAA, 8'h00, 4'b1001, "R3");
    // R4: logic modes update only Z
    apply(1'b1, 4'h4, 8'h03, 8'h05, 4'b1111, "R4");
    apply(1'b1, 4'h5, 8'h00, 8'h00, 4'b0111, "R4");
    apply(1'b1, 4'h6, 8'hF0, 8'hF0, 4'b0010, "R4");
    // R5: rotates
    apply(1'b1, 4'hA, 8'h01, 8'h80, 4'b0000, "R5");
    apply(1'b1, 4'hB, 8'h03, 8'h01, 4'b1111, "R5");
    // R6: logical shifts
    apply(1'b1, 4'hC, 8'h01, 8'h80, 4'b0011, "R6");
    apply(1'b1, 4'hD, 8'h03, 8'h04, 4'b0011, "R6");
    // R7: arithmetic shift right
    apply(1'b1, 4'hE, 8'h01, 8'h81, 4'b0001, "R7");
    apply(1'b1, 4'hE, 8'h03, 8'h04, 4'b0010, "R7");
    // R8 + R11: zero count with upper count bits set, opposing flags
    apply(1'b1, 4'hC, 8'hF8, 8'h00, 4'b0100, "R8");
    apply(1'b1, 4'hD, 8'h08, 8'h01, 4'b1000, "R8");
    apply(1'b1, 4'hE, 8'h10, 8'h80, 4'b1101, "R8");
    // R11: upper bits of opA ignored for rotate/shift counts
    apply(1'b1, 4'hA, 8'hF9, 8'h81, 4'b0000, "R11");
    apply(1'b1, 4'hD, 8'hFA, 8'hC4, 4'b0000, "R11");
    // R9: flag positions via random sweep
    for (int i = 0; i < 400; i++) begin
      logic [3:0] m;
      logic en;
      m = 4'($urandom);
      en = ($urandom % 8) != 0;
      apply(en, m, 8'($urandom), 8'($urandom), 4'($urandom), {tagOf(en, m), "/R9"});
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule